// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer, modelled entirely in synchronous logic on the fast input clock. The division ratio is N = P·B + A. A dual-modulus prescaler divides by either P+1 or P. A main counter counts B prescaler periods per frame. While the frame index is below A, the main counter holds the prescaler at P+1, which swallows one extra input cycle in each of the first A periods. When the last prescaler period of a frame ends, a load event reloads the counters and, one cycle later, drives a single-cycle pulse toward the phase detector.

The prescaler is a synchronous divide-by-4/5 core followed by a binary extension counter. The extension counter has one stage for the 8/9 setting and three stages for the 32/33 setting. A write port places a new A, B and modulus selection into a shadow register. The active configuration copies the shadow only at a load event or during reset, so no frame ever runs with a mix of old and new values. If a configuration breaks the scheme (A greater than B, or B below 3), the block raises an error flag and produces no pulses. Frames keep running, so that a corrected setting can be taken up at the next frame end.

Top module: `fbdiv_swallow`

## Requirements
- R1: With the modulus select low, P = 8. With it high, P = 32. For a legal setting, the number of rising clock edges between consecutive output pulses equals P·B + A.
- R2: While reset is high, the output pulse stays low. After reset is released, the first pulse is high in the cycle that follows the N-th rising edge after release.
- R3: Every output pulse lasts exactly one clock cycle.
- R4: Within a frame, the prescaler runs at P+1 for the first A of its B periods and at P for the remaining periods. When A = 0, every period runs at P. Both A = 0 and A = B give an interval of exactly P·B + A.
- R5: A write during a running frame does not change the length of that frame. The written values govern the frame that starts after the next output pulse.
- R6: A configuration written before or while reset is asserted governs the first frame after reset. Reset does not discard a configuration written earlier.
- R7: If A > B or B < 3, the error flag is high and no output pulse is produced while that configuration is active.
- R8: During an error frame, frames of B prescaler periods keep running. A legal configuration written during such a frame becomes active at that frame's end. At that point the error flag falls, and the next pulse follows N edges after the cycle in which the flag is first low.
- R9: The boundary values are handled: B = 3 with A = 0, A = B = 3, and A = 31 with the 32/33 modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the shadow configuration |
| cfg_psel | input | 1 | Modulus select: 0 gives 8/9, 1 gives 32/33 |
| cfg_a | input | 5 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| div_pulse | output | 1 | One-cycle pulse toward the phase detector, once per N cycles |
| cfg_err | output | 1 | The active configuration is illegal, so pulses are suppressed |

## Verification
Some properties are checked by the assertions on every cycle. Each frame ends after exactly P·B + A cycles of its own active setting. The modulus control holds steady across a prescaler period and stays off when A is zero. The active setting changes only at a load event. No pulse follows a cycle in which the error flag is high, and no pulse lasts longer than one cycle. Other behaviour can only be shown by the bench scenarios, which observe the ports. These scenarios cover the first-pulse timing after reset, the deferral of a write made during a running frame, the retention of the setting across reset, and recovery from an illegal setting.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int A_W        = 5;
    localparam int B_W        = 13;
    localparam int B_MIN      = 3;
    localparam int CORE_W     = 3;
    localparam int EXT_W      = 3;
    localparam int EXT_STG_LO = 1;
    localparam int EXT_STG_HI = 3;
    localparam int CORE_BASE  = 4;
    localparam int P_LO       = CORE_BASE << EXT_STG_LO;
    localparam int P_HI       = CORE_BASE << EXT_STG_HI;
    localparam int LEN_W      = 20;

    typedef enum logic {
        PSEL_8_9   = 1'b0,
        PSEL_32_33 = 1'b1
    } psel_e;

    typedef struct packed {
        psel_e          psel;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } div_cfg_t;

    function automatic logic [EXT_W-1:0] ext_last(psel_e p);
        return (p == PSEL_32_33) ? EXT_W'((1 << EXT_STG_HI) - 1)
                                 : EXT_W'((1 << EXT_STG_LO) - 1);
    endfunction

    function automatic logic cfg_ok(div_cfg_t c);
        return (c.b >= B_W'(B_MIN)) && (B_W'(c.a) <= c.b);
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(div_cfg_t c);
        logic [LEN_W-1:0] p;
        p = (c.psel == PSEL_32_33) ? LEN_W'(P_HI) : LEN_W'(P_LO);
        return p * LEN_W'(c.b) + LEN_W'(c.a);
    endfunction

endpackage

// File: rtl/fbdiv_core45.sv
module fbdiv_core45 import fbdiv_pkg::*; #(
    parameter int CW = CORE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic five,
    output logic done
);
    localparam logic [CW-1:0] END4 = CW'(CORE_BASE - 1);
    localparam logic [CW-1:0] END5 = CW'(CORE_BASE);

    logic [CW-1:0] st_q;

    assign done = (st_q == (five ? END5 : END4));

    always_ff @(posedge clk) begin
        if (rst)       st_q <= '0;
        else if (done) st_q <= '0;
        else           st_q <= st_q + 1'b1;
    end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler import fbdiv_pkg::*; #(
    parameter int EW = EXT_W
) (
    input  logic  clk,
    input  logic  rst,
    input  psel_e psel,
    input  logic  mc,
    output logic  tick
);
    logic [EW-1:0] ext_q;
    logic          at_last;
    logic          core_done;

    assign at_last = (ext_q == EW'(ext_last(psel)));
    assign tick    = core_done && at_last;

    fbdiv_core45 #(.CW(CORE_W)) u_core (
        .clk  (clk),
        .rst  (rst),
        .five (mc && at_last),
        .done (core_done)
    );

    always_ff @(posedge clk) begin
        if (rst)            ext_q <= '0;
        else if (core_done) ext_q <= at_last ? '0 : ext_q + 1'b1;
    end
endmodule

// File: rtl/fbdiv_swallow_ctr.sv
module fbdiv_swallow_ctr import fbdiv_pkg::*; #(
    parameter int AW = A_W,
    parameter int BW = B_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [AW-1:0] a_val,
    input  logic [BW-1:0] b_val,
    output logic          mc,
    output logic          load
);
    logic [BW-1:0] idx_q;
    logic          frame_end;

    assign frame_end = (idx_q == BW'(b_val - 1'b1));
    assign load      = tick && frame_end;
    assign mc        = (BW'(a_val) > idx_q);

    always_ff @(posedge clk) begin
        if (rst)       idx_q <= '0;
        else if (tick) idx_q <= frame_end ? '0 : idx_q + 1'b1;
    end
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow import fbdiv_pkg::*; #(
    parameter int AW = A_W,
    parameter int BW = B_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          cfg_psel,
    input  logic [AW-1:0] cfg_a,
    input  logic [BW-1:0] cfg_b,
    output logic          div_pulse,
    output logic          cfg_err
);
    div_cfg_t shadow_q, shadow_d, active_q;
    logic     psc_tick, mod_ctl, frame_load, pulse_q;

    always_comb begin
        shadow_d = shadow_q;
        if (cfg_wr) begin
            shadow_d.psel = psel_e'(cfg_psel);
            shadow_d.a    = cfg_a;
            shadow_d.b    = cfg_b;
        end
    end

    // shadow keeps its contents through reset
    always_ff @(posedge clk) shadow_q <= shadow_d;

    always_ff @(posedge clk) begin
        if (rst || frame_load) active_q <= shadow_d;
    end

    fbdiv_prescaler #(.EW(EXT_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .psel (active_q.psel),
        .mc   (mod_ctl),
        .tick (psc_tick)
    );

    fbdiv_swallow_ctr #(.AW(AW), .BW(BW)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .tick  (psc_tick),
        .a_val (active_q.a),
        .b_val (active_q.b),
        .mc    (mod_ctl),
        .load  (frame_load)
    );

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= frame_load && cfg_ok(active_q);
    end

    assign div_pulse = pulse_q;
    assign cfg_err   = !cfg_ok(active_q);
endmodule

// File: rtl/fbdiv_swallow_chk.sv
module fbdiv_swallow_chk import fbdiv_pkg::*; (
    input logic     clk,
    input logic     rst,
    input logic     div_pulse,
    input logic     cfg_err,
    input logic     tick,
    input logic     load,
    input logic     mc,
    input div_cfg_t active
);
    logic [LEN_W-1:0] frm_cnt;

    always_ff @(posedge clk) begin
        if (rst || load) frm_cnt <= LEN_W'(1);
        else             frm_cnt <= frm_cnt + 1'b1;
    end

    p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
        (load && !cfg_err) |-> (frm_cnt == frame_len(active)));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    p_mc_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mc));

    p_mc_off_a0_r4: assert property (@(posedge clk) disable iff (rst)
        (active.a == '0) |-> !mc);

    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));

    p_err_silent_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> !div_pulse);
endmodule

bind fbdiv_swallow fbdiv_swallow_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err),
    .tick      (psc_tick),
    .load      (frame_load),
    .mc        (mod_ctl),
    .active    (active_q)
);

// File: tb/tb_fbdiv_swallow.sv
module tb_fbdiv_swallow;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_psel = 1'b0;
    logic [4:0]  cfg_a = '0;
    logic [12:0] cfg_b = 13'd3;
    logic        div_pulse, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    fbdiv_swallow dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_psel  (cfg_psel),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .div_pulse (div_pulse),
        .cfg_err   (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio(input bit p, input int a, input int b);
        return (p ? 32 : 8) * b + a;
    endfunction

    task automatic write_cfg(input bit p, input int a, input int b);
        @(negedge clk);
        cfg_psel = p;
        cfg_a    = 5'(a);
        cfg_b    = 13'(b);
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic reset_run(input bit do_wr, input bit p, input int a, input int b);
        @(negedge clk);
        rst = 1'b1;
        if (do_wr) write_cfg(p, a, b);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_pulse(output int at, input int limit);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (div_pulse) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic measure(input string req, input bit p, input int a, input int b,
                           input int frames, input int start);
        int exp_n, last, at;
        exp_n = ratio(p, a, b);
        last  = start;
        for (int k = 0; k < frames; k++) begin
            wait_pulse(at, exp_n + 8);
            check(at - last == exp_n, req, at - last, exp_n);
            @(negedge clk);
            check(div_pulse == 1'b0, "R3 pulse width", int'(div_pulse), 0);
            last = at;
        end
    endtask

    // R2: quiet outputs during reset with a legal setting
    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1;
        write_cfg(1'b0, 1, 4);
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R2 no pulse in reset", int'(div_pulse), 0);
        check(cfg_err == 1'b0, "R2 flag clear in reset", int'(cfg_err), 0);
    endtask

    task automatic t_divide(input string req, input bit p, input int a, input int b);
        reset_run(1'b1, p, a, b);
        check(cfg_err == 1'b0, {req, " flag"}, int'(cfg_err), 0);
        measure(req, p, a, b, 3, 0);
    endtask

    // R5: mid-frame write deferred; R6: setting kept across reset
    task automatic t_shadow();
        int at;
        reset_run(1'b1, 1'b0, 2, 10);
        wait_pulse(at, 100);
        check(at == 82, "R5 first interval", at, 82);
        repeat (20) @(negedge clk);
        write_cfg(1'b1, 4, 6);
        measure("R5 old frame kept", 1'b0, 2, 10, 1, at);
        measure("R5 new setting", 1'b1, 4, 6, 2, at + 82);
        reset_run(1'b0, 1'b0, 0, 0);
        measure("R6 kept across reset", 1'b1, 4, 6, 1, 0);
    endtask

    // R7: illegal settings; R8: recovery
    task automatic t_error();
        int at, fall;
        reset_run(1'b1, 1'b1, 0, 2);
        @(negedge clk);
        check(cfg_err == 1'b1, "R7 flag B<3", int'(cfg_err), 1);
        wait_pulse(at, 300);
        check(at == -1, "R7 silent B<3", at, -1);
        reset_run(1'b1, 1'b0, 9, 4);
        @(negedge clk);
        check(cfg_err == 1'b1, "R7 flag A>B", int'(cfg_err), 1);
        wait_pulse(at, 200);
        check(at == -1, "R7 silent A>B", at, -1);
        write_cfg(1'b0, 1, 5);
        fall = -1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!cfg_err) begin
                fall = cyc;
                break;
            end
        end
        check(fall != -1, "R8 flag falls", fall, 0);
        wait_pulse(at, 60);
        check(at - fall == 41, "R8 recovery interval", at - fall, 41);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_divide("R9 R4 B=3 A=0", 1'b0, 0, 3);
        t_divide("R9 R4 A=B=3", 1'b0, 3, 3);
        t_divide("R9 R1 A=31 P32", 1'b1, 31, 40);
        t_divide("R1 P32 A=0", 1'b1, 0, 5);
        t_divide("R1 R2 P8", 1'b0, 7, 100);
        for (int r = 0; r < 6; r++) begin
            int rb, ra;
            bit rp;
            rb = int'($urandom_range(120, 3));
            ra = int'($urandom_range((rb < 31) ? rb : 31, 0));
            rp = 1'(r % 2);
            t_divide("R1 random", rp, ra, rb);
        end
        t_shadow();
        t_error();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule